// File: doc/BRIEF.md
# Amplifier Control and Trim Register Bank

This block is a small memory-mapped register bank that governs a set of analog amplifier channels (three by default). Software reads and writes three 32-bit registers over a single-cycle bus. The control word sets, for each channel, power-down, low-power operation, the calibration pair under test and a set of input-routing switches. It also holds a shared supply-range bit and a routing switch that only one channel has. The bank drives those settings straight onto per-channel output pins. It also drives a derived switch that is closed whenever either of the channel's two inverting-input switches is closed.

Two trim registers hold user offset-trim codes, one set for normal operation and one for low-power operation. Factory codes for both sets arrive on input ports, and the user registers take those values at reset. Each channel receives a 10-bit effective trim word. A single write-only select bit picks factory or user codes for all channels, and the channel's own low-power bit picks the normal or the low-power set. Comparator outputs from the analog side are sampled every clock into read-only status bits, so that calibration software can watch for the trim code at which the comparator flips.

Top module: `amp_trim_regbank`

## Requirements
- R1: After reset, with comparator inputs low, offset 0x00 reads 0x00010101, every power-down output is 1, every other control output is 0 and the supply-range output is 0.
- R2: After reset, offset 0x04 reads the factory normal trim port and offset 0x08 reads the factory low-power trim port, both with bits 31:30 at 0. The trim outputs equal the factory normal port.
- R3: In the control word, channel c owns the byte at bits 8c+7:8c, laid out as bit0 power-down, bit1 S3, bit2 S4, bit3 S5, bit4 S6, bit5 cal-low, bit6 cal-high and bit7 low-power. Bit 24+c is the channel's SanA switch and bit 27 is the extra switch of channel index 1. Every one of these outputs takes the written value on the clock edge of the write, whatever the power-down state, and the register reads it back.
- R4: The derived switch output of each channel is 1 exactly when that channel's S3 or S4 bit is 1.
- R5: The cal-high output is 1 only when cal-high=1 and cal-low=0, and the cal-low output is 1 only when cal-low=1 and cal-high=0.
- R6: A control write updates bit 28 (supply range) only if all power-down bits were 1 before the write. Otherwise bit 28 keeps its value while the rest of the word is still written.
- R7: Bit 31 of offset 0x04 selects user (1) or factory (0) trims for all channels, resets to 0 and always reads 0. Bit 30 reads 0.
- R8: The trim output of channel c is at bits 10c+9:10c, with the PMOS code in the lower 5 bits and the NMOS code in the upper 5. Its source is the user or factory set according to the select bit, and low-power or normal according to the channel's low-power bit.
- R9: Control bits 29+c read the comparator input of channel c as sampled at the previous clock edge, and writes to those bits have no effect.
- R10: Writes to 0x04 and 0x08 store bits 29:0, and bits 31:30 of 0x08 read 0. Unmapped offsets read 0 and ignore writes, and reads return 0 while sel_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | Write (1) or read (0) |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from address |
| cal_cmp_i | input | NUM_CH | Calibration comparator level per channel |
| fact_trim_nrm_i | input | NUM_CH*2*TRIM_HALF_W | Factory normal-mode trims |
| fact_trim_lp_i | input | NUM_CH*2*TRIM_HALF_W | Factory low-power trims |
| pwr_dn_o | output | NUM_CH | Power-down per channel |
| lp_mode_o | output | NUM_CH | Low-power mode per channel |
| cal_hi_o | output | NUM_CH | Effective NMOS-pair calibration |
| cal_lo_o | output | NUM_CH | Effective PMOS-pair calibration |
| sw3_en_o | output | NUM_CH | Switch S3 closed |
| sw4_en_o | output | NUM_CH | Switch S4 closed |
| sw5_en_o | output | NUM_CH | Switch S5 closed |
| sw6_en_o | output | NUM_CH | Switch S6 closed |
| swa_en_o | output | NUM_CH | Switch SanA closed |
| swb_en_o | output | NUM_CH | Derived switch SanB closed |
| sw7_en_o | output | 1 | Extra switch of channel index 1 |
| pwr_range_o | output | 1 | Supply range select |
| trim_o | output | NUM_CH*2*TRIM_HALF_W | Effective trim words |

## Verification
The bench sweeps all 256 byte values through each channel field, so any slip in bit order, a derived switch driven from the wrong bits, or a calibration pair enabled with both bits set is exposed. The supply-range guard is driven through a sequence in which the power-down bits change within the same write. A design that judged the guard on the new value instead of the old one would flip the range bit when it should hold it. All sixteen combinations of the select bit and the per-channel low-power bits are checked against a computed trim mux. A swapped selection, or a select bit that reads back as 1, would show there. Comparator sampling is checked one edge after each of the eight input patterns, with writes aimed at the status bits.

// File: rtl/amp_trim_pkg.sv
`timescale 1ns/1ps
package amp_trim_pkg;
   localparam int unsigned REG_W        = 32;
   localparam int unsigned MAX_CH       = 3;
   localparam int unsigned CH_FIELD_W   = 8;
   localparam int unsigned SANA_LSB     = 24;
   localparam int unsigned S7_BIT       = 27;
   localparam int unsigned RANGE_BIT    = 28;
   localparam int unsigned CALOUT_LSB   = 29;
   localparam int unsigned USER_SEL_BIT = 31;
   localparam int unsigned TRIM_FIELD_W = 30;
   localparam int unsigned OFS_CTRL     = 0;
   localparam int unsigned OFS_TRIM_NRM = 4;
   localparam int unsigned OFS_TRIM_LP  = 8;

   // One channel byte of the control word, bit 0 at the bottom.
   typedef struct packed {
      logic lpm;
      logic cal_h;
      logic cal_l;
      logic s6;
      logic s5;
      logic s4;
      logic s3;
      logic pd;
   } chan_ctl_t;

   localparam chan_ctl_t CHAN_RST = chan_ctl_t'(8'h01);
endpackage

// File: rtl/amp_ctrl_reg.sv
`timescale 1ns/1ps
module amp_ctrl_reg
   import amp_trim_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned S7_CH  = 1
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     wr_en_i,
   input  logic [REG_W-1:0]         wdata_i,
   input  logic [NUM_CH-1:0]        cal_cmp_i,
   output chan_ctl_t [NUM_CH-1:0]   chan_o,
   output logic [NUM_CH-1:0]        sana_o,
   output logic                     s7_o,
   output logic                     range_o,
   output logic [REG_W-1:0]         rdata_o
);
   chan_ctl_t [NUM_CH-1:0] chan_q;
   logic [NUM_CH-1:0]      sana_q;
   logic [NUM_CH-1:0]      calout_q;
   logic                   range_q;
   logic                   s7_q;
   logic                   all_pd;

   wire unused_wdata = ^wdata_i;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      chan_q[c] <= CHAN_RST;
         else if (wr_en_i) chan_q[c] <= chan_ctl_t'(wdata_i[c*CH_FIELD_W +: CH_FIELD_W]);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sana_q <= '0;
      else if (wr_en_i) sana_q <= wdata_i[SANA_LSB +: NUM_CH];
   end

   // Range bit is guarded by the power-down state held before the write.
   always_comb begin
      all_pd = 1'b1;
      for (int c = 0; c < NUM_CH; c++) all_pd = all_pd & chan_q[c].pd;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                range_q <= 1'b0;
      else if (wr_en_i && all_pd) range_q <= wdata_i[RANGE_BIT];
   end

   // Status samples every edge, also during reset.
   always_ff @(posedge clk_i) calout_q <= cal_cmp_i;

   if (S7_CH < NUM_CH) begin : g_s7
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      s7_q <= 1'b0;
         else if (wr_en_i) s7_q <= wdata_i[S7_BIT];
      end
   end else begin : g_no_s7
      assign s7_q = 1'b0;
   end

   always_comb begin
      rdata_o = '0;
      for (int c = 0; c < NUM_CH; c++) rdata_o[c*CH_FIELD_W +: CH_FIELD_W] = chan_q[c];
      rdata_o[SANA_LSB +: NUM_CH]   = sana_q;
      rdata_o[S7_BIT]               = s7_q;
      rdata_o[RANGE_BIT]            = range_q;
      rdata_o[CALOUT_LSB +: NUM_CH] = calout_q;
   end

   assign chan_o  = chan_q;
   assign sana_o  = sana_q;
   assign s7_o    = s7_q;
   assign range_o = range_q;
endmodule

// File: rtl/amp_trim_reg.sv
`timescale 1ns/1ps
module amp_trim_reg #(
   parameter int unsigned TRIM_W = 30
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [TRIM_W-1:0] wdata_i,
   input  logic [TRIM_W-1:0] fact_i,
   output logic [TRIM_W-1:0] user_o
);
   logic [TRIM_W-1:0] user_q;

   // Reset loads the factory codes so user mode starts from them.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      user_q <= fact_i;
      else if (wr_en_i) user_q <= wdata_i;
   end

   assign user_o = user_q;
endmodule

// File: rtl/amp_chan_out.sv
`timescale 1ns/1ps
module amp_chan_out #(
   parameter int unsigned HALF_W = 5,
   localparam int unsigned CH_W  = 2 * HALF_W
) (
   input  logic            s3_i,
   input  logic            s4_i,
   input  logic            cal_h_i,
   input  logic            cal_l_i,
   input  logic            lpm_i,
   input  logic            user_sel_i,
   input  logic [CH_W-1:0] fact_nrm_i,
   input  logic [CH_W-1:0] fact_lp_i,
   input  logic [CH_W-1:0] user_nrm_i,
   input  logic [CH_W-1:0] user_lp_i,
   output logic            swb_o,
   output logic            cal_hi_o,
   output logic            cal_lo_o,
   output logic [CH_W-1:0] trim_o
);
   logic [CH_W-1:0] nrm_src;
   logic [CH_W-1:0] lp_src;

   assign swb_o    = s3_i | s4_i;
   assign cal_hi_o = cal_h_i & ~cal_l_i;
   assign cal_lo_o = cal_l_i & ~cal_h_i;

   assign nrm_src = user_sel_i ? user_nrm_i : fact_nrm_i;
   assign lp_src  = user_sel_i ? user_lp_i  : fact_lp_i;
   assign trim_o  = lpm_i ? lp_src : nrm_src;
endmodule

// File: rtl/amp_trim_regbank.sv
`timescale 1ns/1ps
module amp_trim_regbank
   import amp_trim_pkg::*;
#(
   parameter int unsigned NUM_CH      = 3,
   parameter int unsigned TRIM_HALF_W = 5,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned S7_CH       = 1,
   localparam int unsigned CH_TRIM_W  = 2 * TRIM_HALF_W,
   localparam int unsigned TRIM_BUS_W = NUM_CH * CH_TRIM_W
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  sel_i,
   input  logic                  wr_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [REG_W-1:0]      wdata_i,
   output logic [REG_W-1:0]      rdata_o,
   input  logic [NUM_CH-1:0]     cal_cmp_i,
   input  logic [TRIM_BUS_W-1:0] fact_trim_nrm_i,
   input  logic [TRIM_BUS_W-1:0] fact_trim_lp_i,
   output logic [NUM_CH-1:0]     pwr_dn_o,
   output logic [NUM_CH-1:0]     lp_mode_o,
   output logic [NUM_CH-1:0]     cal_hi_o,
   output logic [NUM_CH-1:0]     cal_lo_o,
   output logic [NUM_CH-1:0]     sw3_en_o,
   output logic [NUM_CH-1:0]     sw4_en_o,
   output logic [NUM_CH-1:0]     sw5_en_o,
   output logic [NUM_CH-1:0]     sw6_en_o,
   output logic [NUM_CH-1:0]     swa_en_o,
   output logic [NUM_CH-1:0]     swb_en_o,
   output logic                  sw7_en_o,
   output logic                  pwr_range_o,
   output logic [TRIM_BUS_W-1:0] trim_o
);
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("NUM_CH must be 1..3");
   end
   if (TRIM_BUS_W > TRIM_FIELD_W) begin : g_bad_trim
      $error("trim fields exceed 30 bits");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must be at least 4");
   end

   logic hit_ctrl, hit_nrm, hit_lp;
   logic user_sel_q;
   logic [REG_W-1:0] ctrl_rd;
   logic [TRIM_BUS_W-1:0] user_nrm, user_lp;
   chan_ctl_t [NUM_CH-1:0] chan;

   assign hit_ctrl = sel_i && (addr_i == ADDR_W'(OFS_CTRL));
   assign hit_nrm  = sel_i && (addr_i == ADDR_W'(OFS_TRIM_NRM));
   assign hit_lp   = sel_i && (addr_i == ADDR_W'(OFS_TRIM_LP));

   amp_ctrl_reg #(.NUM_CH(NUM_CH), .S7_CH(S7_CH)) u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (hit_ctrl && wr_i),
      .wdata_i  (wdata_i),
      .cal_cmp_i(cal_cmp_i),
      .chan_o   (chan),
      .sana_o   (swa_en_o),
      .s7_o     (sw7_en_o),
      .range_o  (pwr_range_o),
      .rdata_o  (ctrl_rd)
   );

   amp_trim_reg #(.TRIM_W(TRIM_BUS_W)) u_trim_nrm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_en_i(hit_nrm && wr_i),
      .wdata_i(wdata_i[TRIM_BUS_W-1:0]),
      .fact_i (fact_trim_nrm_i),
      .user_o (user_nrm)
   );

   amp_trim_reg #(.TRIM_W(TRIM_BUS_W)) u_trim_lp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_en_i(hit_lp && wr_i),
      .wdata_i(wdata_i[TRIM_BUS_W-1:0]),
      .fact_i (fact_trim_lp_i),
      .user_o (user_lp)
   );

   // Write-only source select shared by every channel.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              user_sel_q <= 1'b0;
      else if (hit_nrm && wr_i) user_sel_q <= wdata_i[USER_SEL_BIT];
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign pwr_dn_o[c]  = chan[c].pd;
      assign lp_mode_o[c] = chan[c].lpm;
      assign sw3_en_o[c]  = chan[c].s3;
      assign sw4_en_o[c]  = chan[c].s4;
      assign sw5_en_o[c]  = chan[c].s5;
      assign sw6_en_o[c]  = chan[c].s6;

      amp_chan_out #(.HALF_W(TRIM_HALF_W)) u_out (
         .s3_i      (chan[c].s3),
         .s4_i      (chan[c].s4),
         .cal_h_i   (chan[c].cal_h),
         .cal_l_i   (chan[c].cal_l),
         .lpm_i     (chan[c].lpm),
         .user_sel_i(user_sel_q),
         .fact_nrm_i(fact_trim_nrm_i[c*CH_TRIM_W +: CH_TRIM_W]),
         .fact_lp_i (fact_trim_lp_i[c*CH_TRIM_W +: CH_TRIM_W]),
         .user_nrm_i(user_nrm[c*CH_TRIM_W +: CH_TRIM_W]),
         .user_lp_i (user_lp[c*CH_TRIM_W +: CH_TRIM_W]),
         .swb_o     (swb_en_o[c]),
         .cal_hi_o  (cal_hi_o[c]),
         .cal_lo_o  (cal_lo_o[c]),
         .trim_o    (trim_o[c*CH_TRIM_W +: CH_TRIM_W])
      );
   end

   always_comb begin
      rdata_o = '0;
      if (hit_ctrl)     rdata_o = ctrl_rd;
      else if (hit_nrm) rdata_o[TRIM_BUS_W-1:0] = user_nrm;
      else if (hit_lp)  rdata_o[TRIM_BUS_W-1:0] = user_lp;
   end
endmodule

// File: rtl/amp_trim_regbank_chk.sv
`timescale 1ns/1ps
module amp_trim_regbank_chk
   import amp_trim_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              sel_i,
   input logic              wr_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [REG_W-1:0]  wdata_i,
   input logic [REG_W-1:0]  rdata_o,
   input logic [NUM_CH-1:0] cal_cmp_i,
   input logic [NUM_CH-1:0] pwr_dn_o,
   input logic [NUM_CH-1:0] cal_hi_o,
   input logic [NUM_CH-1:0] cal_lo_o,
   input logic [NUM_CH-1:0] swb_en_o,
   input logic              pwr_range_o
);
   logic ctrl_wr, nrm_rd, ctrl_rd;
   assign ctrl_wr = sel_i && wr_i && (addr_i == ADDR_W'(OFS_CTRL));
   assign nrm_rd  = sel_i && !wr_i && (addr_i == ADDR_W'(OFS_TRIM_NRM));
   assign ctrl_rd = sel_i && !wr_i && (addr_i == ADDR_W'(OFS_CTRL));

   // R6
   range_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr && !(&pwr_dn_o)) |=> $stable(pwr_range_o));

   // R7
   sel_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nrm_rd |-> (rdata_o[31:30] == 2'b00));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      // R3
      pd_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ctrl_wr |=> (pwr_dn_o[c] == $past(wdata_i[c*CH_FIELD_W])));
      // R4
      swb_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ctrl_wr |=> (swb_en_o[c] ==
            ($past(wdata_i[c*CH_FIELD_W+1]) | $past(wdata_i[c*CH_FIELD_W+2]))));
      // R5
      cal_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ctrl_wr && wdata_i[c*CH_FIELD_W+5] && wdata_i[c*CH_FIELD_W+6])
         |=> (!cal_hi_o[c] && !cal_lo_o[c]));
      // R9
      calout_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ctrl_rd |-> (rdata_o[CALOUT_LSB+c] == $past(cal_cmp_i[c])));
   end
endmodule

bind amp_trim_regbank amp_trim_regbank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .sel_i      (sel_i),
   .wr_i       (wr_i),
   .addr_i     (addr_i),
   .wdata_i    (wdata_i),
   .rdata_o    (rdata_o),
   .cal_cmp_i  (cal_cmp_i),
   .pwr_dn_o   (pwr_dn_o),
   .cal_hi_o   (cal_hi_o),
   .cal_lo_o   (cal_lo_o),
   .swb_en_o   (swb_en_o),
   .pwr_range_o(pwr_range_o)
);

// File: tb/amp_trim_regbank_tb_top.sv
`timescale 1ns/1ps
module amp_trim_regbank_tb_top;
   localparam logic [29:0] FN = 30'h0C3A_5E17;
   localparam logic [29:0] FL = 30'h31D2_48A9;
   localparam logic [29:0] UN = 30'h1B6E_2D34;
   localparam logic [29:0] UL = 30'h2479_C0F5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel = 1'b0, wr = 1'b0;
   logic [3:0] addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic [2:0] cal_cmp = '0;
   logic [2:0] pd, lpm, chi, clo, s3, s4, s5, s6, sa, sb;
   logic s7, rng;
   logic [29:0] trim;

   int n_chk = 0, n_fail = 0;
   logic [31:0] m_ctrl;
   logic        m_sel;
   logic [29:0] m_un, m_ul;

   always #2.5 clk = ~clk;

   amp_trim_regbank dut_i (
      .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .cal_cmp_i(cal_cmp),
      .fact_trim_nrm_i(FN), .fact_trim_lp_i(FL),
      .pwr_dn_o(pd), .lp_mode_o(lpm), .cal_hi_o(chi), .cal_lo_o(clo),
      .sw3_en_o(s3), .sw4_en_o(s4), .sw5_en_o(s5), .sw6_en_o(s6),
      .swa_en_o(sa), .swb_en_o(sb), .sw7_en_o(s7), .pwr_range_o(rng),
      .trim_o(trim)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
      sel = 1'b1; wr = 1'b0; addr = a;
      #1 d = rdata;
      sel = 1'b0;
   endtask

   task automatic ctrl_wr(input logic [31:0] d);
      logic all_pd;
      all_pd = m_ctrl[0] & m_ctrl[8] & m_ctrl[16];
      bus_wr(4'h0, d);
      m_ctrl[27:0] = d[27:0];
      if (all_pd) m_ctrl[28] = d[28];
   endtask

   function automatic logic [29:0] exp_trim();
      logic [29:0] t;
      for (int c = 0; c < 3; c++) begin
         if (m_ctrl[8*c+7]) t[10*c +: 10] = m_sel ? m_ul[10*c +: 10] : FL[10*c +: 10];
         else               t[10*c +: 10] = m_sel ? m_un[10*c +: 10] : FN[10*c +: 10];
      end
      return t;
   endfunction

   task automatic check_outputs(input string tag);
      logic [2:0] e_pd, e_s3, e_s4, e_s5, e_s6, e_lpm, e_chi, e_clo, e_sb;
      for (int c = 0; c < 3; c++) begin
         e_pd[c]  = m_ctrl[8*c];
         e_s3[c]  = m_ctrl[8*c+1];
         e_s4[c]  = m_ctrl[8*c+2];
         e_s5[c]  = m_ctrl[8*c+3];
         e_s6[c]  = m_ctrl[8*c+4];
         e_clo[c] = m_ctrl[8*c+5] & ~m_ctrl[8*c+6];
         e_chi[c] = m_ctrl[8*c+6] & ~m_ctrl[8*c+5];
         e_lpm[c] = m_ctrl[8*c+7];
         e_sb[c]  = e_s3[c] | e_s4[c];
      end
      check({tag, " R3 switches/pd/lpm"},
            {5'b0, rng, s7, sa, lpm, s6, s5, s4, s3, pd},
            {5'b0, m_ctrl[28], m_ctrl[27], m_ctrl[26:24], e_lpm, e_s6, e_s5, e_s4, e_s3, e_pd});
      check({tag, " R4 derived switch"}, {29'b0, sb}, {29'b0, e_sb});
      check({tag, " R5 cal exclusivity"}, {26'b0, chi, clo}, {26'b0, e_chi, e_clo});
   endtask

   initial begin
      logic [31:0] rd;
      m_ctrl = 32'h0001_0101; m_sel = 1'b0; m_un = FN; m_ul = FL;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_rd(4'h0, rd); check("R1 ctrl reset value", rd, 32'h0001_0101);
      check_outputs("R1");
      // R2 user trims loaded from factory
      bus_rd(4'h4, rd); check("R2 normal trim reset", rd, {2'b00, FN});
      bus_rd(4'h8, rd); check("R2 low-power trim reset", rd, {2'b00, FL});
      check("R2 trim output at reset", {2'b0, trim}, {2'b0, FN});

      // R3 R4 R5 every byte value through every channel field
      for (int i = 0; i < 256; i++) begin
         logic [7:0] b;
         b = 8'(i);
         ctrl_wr({4'b0000, b[3:0], b, ~b, b});
         check_outputs("sweep");
         bus_rd(4'h0, rd); check("R3 ctrl readback", rd, m_ctrl);
      end

      // R6 range guard, judged on power-down state before the write
      ctrl_wr(32'h0001_0101);
      ctrl_wr(32'h1001_0101);
      check("R6 range set while all down", {31'b0, rng}, 32'd1);
      ctrl_wr(32'h1001_0100);
      check("R6 range write accepted, pd0 cleared", {28'b0, rng, pd}, {28'b0, 1'b1, 3'b110});
      ctrl_wr(32'h0001_0108);
      check("R6 range held while ch0 up", {31'b0, rng}, 32'd1);
      check("R6 other bits still written", {29'b0, s5}, 32'd1);
      ctrl_wr(32'h0001_0101);
      check("R6 held when pd rises in same write", {28'b0, rng, pd}, {28'b0, 1'b1, 3'b111});
      ctrl_wr(32'h0001_0101);
      check("R6 range cleared once all down", {31'b0, rng}, 32'd0);
      bus_rd(4'h0, rd); check("R6 readback", rd, m_ctrl);

      // R7 R8 trim source selection
      bus_wr(4'h8, {2'b11, UL}); m_ul = UL;
      for (int s = 0; s < 2; s++) begin
         for (int l = 0; l < 8; l++) begin
            logic [2:0] lv;
            lv = 3'(l);
            bus_wr(4'h4, {s[0], 1'b1, UN}); m_sel = s[0]; m_un = UN;
            ctrl_wr({15'b0, lv[2], 7'h01, lv[1], 7'h01, lv[0], 7'h01});
            check("R8 effective trim", {2'b0, trim}, {2'b0, exp_trim()});
            bus_rd(4'h4, rd); check("R7 select reads zero", rd, {2'b00, UN});
         end
      end

      // R9 comparator sampling and write immunity
      for (int v = 0; v < 8; v++) begin
         cal_cmp = 3'(v);
         @(negedge clk);
         bus_rd(4'h0, rd);
         check("R9 comparator status", {29'b0, rd[31:29]}, 32'(v));
      end
      cal_cmp = 3'b000;
      ctrl_wr(32'hE001_0101);
      bus_rd(4'h0, rd); check("R9 status ignores writes", rd, m_ctrl);

      // R10 reserved bits, unmapped offsets, idle strobe
      bus_wr(4'h8, 32'hFFFF_FFFF); m_ul = 30'h3FFF_FFFF;
      bus_rd(4'h8, rd); check("R10 lp reserved read zero", rd, 32'h3FFF_FFFF);
      bus_wr(4'hC, 32'hFFFF_FFFF);
      bus_rd(4'hC, rd); check("R10 unmapped reads zero", rd, 32'h0);
      bus_rd(4'h0, rd); check("R10 unmapped write ignored", rd, m_ctrl);
      bus_rd(4'h4, rd); check("R10 nrm untouched", rd, {2'b00, m_un});
      wr = 1'b0; addr = 4'h4; sel = 1'b0;
      #1 check("R10 idle read zero", rdata, 32'h0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule